// File: doc/BRIEF.md
# SD Command and Response Engine

This block runs the command half of an SD/MMC host. A one-cycle `start` launches a transaction. The engine builds a 48-bit command frame from a 6-bit opcode and a 32-bit argument, adds a CRC7, and shifts the frame out on the CMD line with the most significant bit first. One bus bit is sent per clock. If the configuration asks for a reply, the engine then watches CMD for the card's start bit. It captures a 48-bit short reply or a 136-bit long reply. The short reply can optionally have its CRC7 verified.

The captured reply is handed over through a 6-byte window: a 32-bit word plus a 16-bit half. A `rsp_full` flag gates the window. Each `rsp_pop` moves the window to the next six bytes. A short reply takes one window. A long reply takes three, and the final byte of the third window is zero padding.

The outcome is held in sticky status bits (finish, error, timeout, CRC error) until the next accepted start. Optional idle clocks can go out ahead of the command. An optional busy phase keeps finish low until DAT0 is released by the card.

Top module: `sdc_cmd_engine`

## Requirements
- R1: The command frame is 48 bits sent MSB first while `cmd_oe` is high: a 0, a 1, the 6-bit opcode, the 32-bit argument MSB first, the 7-bit CRC, and a closing 1. The CRC uses x^7+x^3+1 over the first 40 bits, starting from zero. When `cmd_oe` is low, `cmd_out` is 1.
- R2: With `cfg_dummy` set, the first frame bit comes DUMMY_CLKS cycles later than it would with `cfg_dummy` clear. During that wait `busy` is high and `cmd_oe` is low.
- R3: With `cfg_rsp_en` clear, the transaction finishes right after the last frame bit. `sts_done` sets, no error bit sets, and `rsp_full` stays low.
- R4: With `cfg_rsp_en` set, a 0 on `cmd_in` after the frame is taken as the reply start bit. From that bit on, 48 bits are captured, or 136 bits when `cfg_rsp_long` is set.
- R5: If no start bit is seen within TIMEOUT_CLKS cycles after the frame, `sts_timeout`, `sts_err` and `sts_done` set and `rsp_full` stays low. A start bit in the last of those cycles is still accepted.
- R6: For a short reply with `cfg_crc_chk` set, reply bits 40..46 are compared with the CRC7 of reply bits 0..39. A mismatch sets `sts_crc_err` and `sts_err`. With `cfg_crc_chk` clear, no CRC error is reported.
- R7: A long reply is never CRC-checked, whatever `cfg_crc_chk` says.
- R8: When capture completes, `rsp_full` rises with window 0 shown. Window k shows reply bytes 6k..6k+5: `rsp_word` holds bytes 6k..6k+3 (byte 6k in bits 31:24) and `rsp_half` holds the next two bytes. Byte 0 is the first bit received. A long reply has three windows, and byte 17 reads 0. A short reply has one window. Each `rsp_pop` advances the window, and `rsp_full` drops after the last window. A pop while `rsp_full` is low has no effect.
- R9: With `cfg_busy_wait` set, `sts_done` stays low after the reply until `dat0_in` reads 1.
- R10: An accepted `start` clears all status bits and `rsp_full`. A `start` while `busy` is high is ignored and does not disturb the frame in flight.
- R11: After reset, the engine is idle: `cmd_oe`=0, `cmd_out`=1, and all status bits and `rsp_full` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bus bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a transaction when idle |
| cmd_op | input | 6 | Command opcode |
| cmd_arg | input | 32 | Command argument |
| cfg_rsp_en | input | 1 | A reply is expected |
| cfg_crc_chk | input | 1 | Verify CRC7 of a short reply |
| cfg_rsp_long | input | 1 | Reply is 136 bits instead of 48 |
| cfg_dummy | input | 1 | Send idle clocks before the frame |
| cfg_busy_wait | input | 1 | Hold finish until DAT0 is high |
| cmd_in | input | 1 | CMD line as seen from the card |
| dat0_in | input | 1 | DAT0 line level |
| rsp_pop | input | 1 | Consume the current reply window |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line output enable |
| busy | output | 1 | Transaction in progress |
| rsp_full | output | 1 | Reply window valid |
| rsp_word | output | 32 | First four bytes of the window |
| rsp_half | output | 16 | Last two bytes of the window |
| sts_done | output | 1 | Transaction finished |
| sts_err | output | 1 | Transaction ended with an error |
| sts_timeout | output | 1 | No reply start bit in time |
| sts_crc_err | output | 1 | Short reply CRC7 mismatch |

## Verification
The bench builds the engine with TIMEOUT_CLKS=20 and DUMMY_CLKS=5, keeping LONG_BITS at 136. The short timeout lets the bench test both sides of the reply deadline cheaply: a start bit in the last allowed cycle, and an exact count of cycles to a timeout. The dummy count of 5 differs from the default, so a delay that ignores the parameter shows up in the gap to the first frame bit. With 136 reply bits, the padded third window of a long reply is reached.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;

    localparam int FRAME_BITS = 48;
    localparam int FILL_BITS  = 48;
    localparam int CRC_SPAN   = 40;
    localparam int SHORT_BITS = 48;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DUMMY = 3'd1,
        ST_SEND  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RECV  = 3'd4,
        ST_BUSY  = 3'd5
    } sdc_state_e;

    // one serial step of the x^7 + x^3 + 1 code
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_head(input logic [CRC_SPAN-1:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) c = crc7_step(c, d[i]);
        return c;
    endfunction

endpackage

// File: rtl/sdc_crc7.sv
`timescale 1ns/1ps
module sdc_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    import sdc_pkg::*;

    logic [6:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear)   crc_d = '0;
        else if (en) crc_d = crc7_step(crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdc_rsp_window.sv
`timescale 1ns/1ps
module sdc_rsp_window #(
    parameter int LONG_BITS = 136,
    parameter int FILLS     = 3,
    parameter int WIN_W     = 2
) (
    input  logic [LONG_BITS-1:0] rx_bits,
    input  logic                 is_long,
    input  logic [WIN_W-1:0]     win_idx,
    output logic [31:0]          word,
    output logic [15:0]          half
);
    import sdc_pkg::*;

    localparam int PAD_BITS = FILLS * FILL_BITS;
    localparam int LONG_PAD = PAD_BITS - LONG_BITS;

    logic [PAD_BITS-1:0]  padded;
    logic [FILL_BITS-1:0] fills [FILLS];
    logic [FILL_BITS-1:0] sel;

    assign padded = is_long ? (PAD_BITS'(rx_bits) << LONG_PAD)
                            : (PAD_BITS'(rx_bits[SHORT_BITS-1:0]) << (PAD_BITS - SHORT_BITS));

    for (genvar g = 0; g < FILLS; g++) begin : g_fill
        assign fills[g] = padded[PAD_BITS-1-g*FILL_BITS -: FILL_BITS];
    end

    always_comb begin
        sel = fills[0];
        for (int i = 0; i < FILLS; i++)
            if (win_idx == WIN_W'(i)) sel = fills[i];
    end

    assign word = sel[FILL_BITS-1 -: 32];
    assign half = sel[15:0];
endmodule

// File: rtl/sdc_cmd_engine.sv
`timescale 1ns/1ps
module sdc_cmd_engine #(
    parameter int LONG_BITS    = 136,
    parameter int TIMEOUT_CLKS = 64,
    parameter int DUMMY_CLKS   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  cmd_op,
    input  logic [31:0] cmd_arg,
    input  logic        cfg_rsp_en,
    input  logic        cfg_crc_chk,
    input  logic        cfg_rsp_long,
    input  logic        cfg_dummy,
    input  logic        cfg_busy_wait,
    input  logic        cmd_in,
    input  logic        dat0_in,
    input  logic        rsp_pop,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic        busy,
    output logic        rsp_full,
    output logic [31:0] rsp_word,
    output logic [15:0] rsp_half,
    output logic        sts_done,
    output logic        sts_err,
    output logic        sts_timeout,
    output logic        sts_crc_err
);
    import sdc_pkg::*;

    localparam int FILLS = (LONG_BITS + FILL_BITS - 1) / FILL_BITS;
    localparam int WIN_W = $clog2(FILLS + 1);
    localparam int MAXC1 = (LONG_BITS > TIMEOUT_CLKS) ? LONG_BITS : TIMEOUT_CLKS;
    localparam int MAXC  = (MAXC1 > DUMMY_CLKS) ? MAXC1 : DUMMY_CLKS;
    localparam int CNT_W = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(TIMEOUT_CLKS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] CRC_END    = CNT_W'(CRC_SPAN);
    localparam logic [WIN_W-1:0] WIN_LONG   = WIN_W'(FILLS - 1);

    typedef struct packed {
        sdc_state_e             st;
        logic [FRAME_BITS-1:0]  tx;
        logic [CNT_W-1:0]       cnt;
        logic [LONG_BITS-1:0]   rx;
        logic                   c_rsp;
        logic                   c_chk;
        logic                   c_long;
        logic                   c_busy;
        logic                   full;
        logic [WIN_W-1:0]       win;
        logic                   done;
        logic                   err;
        logic                   tmo;
        logic                   crcerr;
    } eng_t;

    eng_t       q, d;
    logic       crc_clr, crc_en, crc_bit;
    logic [6:0] crc_rx;
    logic [CNT_W-1:0] len_last;
    logic [WIN_W-1:0] win_last;
    logic [39:0]      head;
    logic             mismatch;

    assign len_last = q.c_long ? LONG_LAST : SHORT_LAST;
    assign win_last = q.c_long ? WIN_LONG : '0;
    assign head     = {2'b01, cmd_op, cmd_arg};

    always_comb begin
        d        = q;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        crc_bit  = cmd_in;
        mismatch = 1'b0;

        if (rsp_pop && q.full) begin
            if (q.win == win_last) d.full = 1'b0;
            else                   d.win  = q.win + 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.done   = 1'b0;
                    d.err    = 1'b0;
                    d.tmo    = 1'b0;
                    d.crcerr = 1'b0;
                    d.full   = 1'b0;
                    d.win    = '0;
                    d.c_rsp  = cfg_rsp_en;
                    d.c_chk  = cfg_crc_chk;
                    d.c_long = cfg_rsp_long;
                    d.c_busy = cfg_busy_wait;
                    d.tx     = {head, crc7_head(head), 1'b1};
                    d.cnt    = '0;
                    crc_clr  = 1'b1;
                    d.st     = cfg_dummy ? ST_DUMMY : ST_SEND;
                end
            end
            ST_DUMMY: begin
                if (q.cnt == DUMMY_LAST) begin
                    d.cnt = '0;
                    d.st  = ST_SEND;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SEND: begin
                d.tx = {q.tx[FRAME_BITS-2:0], 1'b1};
                if (q.cnt == FRAME_LAST) begin
                    d.cnt = '0;
                    if (q.c_rsp) begin
                        d.st = ST_WAIT;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (!cmd_in) begin
                    d.rx   = {q.rx[LONG_BITS-2:0], 1'b0};
                    d.cnt  = CNT_W'(1);
                    crc_en = 1'b1;
                    d.st   = ST_RECV;
                end else if (q.cnt == WAIT_LAST) begin
                    d.tmo  = 1'b1;
                    d.err  = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RECV: begin
                d.rx   = {q.rx[LONG_BITS-2:0], cmd_in};
                d.cnt  = q.cnt + 1'b1;
                crc_en = (q.cnt < CRC_END);
                if (q.cnt == len_last) begin
                    mismatch = q.c_chk && !q.c_long && (q.rx[6:0] != crc_rx);
                    d.crcerr = mismatch;
                    d.err    = mismatch;
                    d.full   = 1'b1;
                    d.win    = '0;
                    d.done   = !q.c_busy;
                    d.st     = q.c_busy ? ST_BUSY : ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (dat0_in) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    sdc_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clr),
        .en    (crc_en),
        .din   (crc_bit),
        .crc   (crc_rx)
    );

    sdc_rsp_window #(
        .LONG_BITS (LONG_BITS),
        .FILLS     (FILLS),
        .WIN_W     (WIN_W)
    ) u_win (
        .rx_bits (q.rx),
        .is_long (q.c_long),
        .win_idx (q.win),
        .word    (rsp_word),
        .half    (rsp_half)
    );

    assign cmd_oe      = (q.st == ST_SEND);
    assign cmd_out     = (q.st == ST_SEND) ? q.tx[FRAME_BITS-1] : 1'b1;
    assign busy        = (q.st != ST_IDLE);
    assign rsp_full    = q.full;
    assign sts_done    = q.done;
    assign sts_err     = q.err;
    assign sts_timeout = q.tmo;
    assign sts_crc_err = q.crcerr;
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
`timescale 1ns/1ps
module sdc_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic rsp_pop,
    input logic cmd_out,
    input logic cmd_oe,
    input logic busy,
    input logic rsp_full,
    input logic sts_done,
    input logic sts_err,
    input logic sts_timeout,
    input logic sts_crc_err
);
    assert_oe_in_txn_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy);

    assert_line_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !sts_done && !sts_err && !rsp_full));

    assert_timeout_no_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sts_timeout |-> (sts_err && !rsp_full && !sts_crc_err));

    assert_crc_flags_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_crc_err) |-> sts_err);

    assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_done) |-> !busy);

    assert_pop_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_pop && !rsp_full && !busy && !start) |=> !rsp_full);
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rsp_pop     (rsp_pop),
    .cmd_out     (cmd_out),
    .cmd_oe      (cmd_oe),
    .busy        (busy),
    .rsp_full    (rsp_full),
    .sts_done    (sts_done),
    .sts_err     (sts_err),
    .sts_timeout (sts_timeout),
    .sts_crc_err (sts_crc_err)
);

// File: tb/sim_sdc_cmd_engine.sv
`timescale 1ns/1ps
module sim_sdc_cmd_engine;

    localparam int TO = 20;
    localparam int DM = 5;

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] arg;
        logic        rsp;
        logic        chk;
        logic        lng;
        logic        dmy;
        logic        bsy;
        logic [7:0]  dly;
        logic        bad;
    } vec_t;

    // op, arg, rsp, chk, lng, dmy, bsy, dly, bad
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0},
        '{6'd17, 32'h0000_1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd19, 1'b0},
        '{6'd8,  32'h0000_01AA, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0,  1'b0},
        '{6'd13, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5,  1'b1},
        '{6'd2,  32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2,  1'b1},
        '{6'd12, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0},
        '{6'd55, 32'hFFFF_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_op = '0;
    logic [31:0] cmd_arg = '0;
    logic        cfg_rsp_en = 1'b0, cfg_crc_chk = 1'b0, cfg_rsp_long = 1'b0;
    logic        cfg_dummy = 1'b0, cfg_busy_wait = 1'b0;
    logic        cmd_in = 1'b1, dat0_in = 1'b1, rsp_pop = 1'b0;
    logic        cmd_out, cmd_oe, busy, rsp_full;
    logic [31:0] rsp_word;
    logic [15:0] rsp_half;
    logic        sts_done, sts_err, sts_timeout, sts_crc_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdc_cmd_engine #(.LONG_BITS(136), .TIMEOUT_CLKS(TO), .DUMMY_CLKS(DM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .cfg_rsp_en(cfg_rsp_en), .cfg_crc_chk(cfg_crc_chk), .cfg_rsp_long(cfg_rsp_long),
        .cfg_dummy(cfg_dummy), .cfg_busy_wait(cfg_busy_wait), .cmd_in(cmd_in),
        .dat0_in(dat0_in), .rsp_pop(rsp_pop), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .busy(busy), .rsp_full(rsp_full), .rsp_word(rsp_word), .rsp_half(rsp_half),
        .sts_done(sts_done), .sts_err(sts_err), .sts_timeout(sts_timeout),
        .sts_crc_err(sts_crc_err)
    );

    function automatic logic [6:0] ref_crc(input logic [39:0] bits);
        logic [6:0] r;
        logic       top;
        r = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            top = r[6] ^ bits[i];
            r   = {r[5:0], 1'b0};
            if (top) r = r ^ 7'b0001001;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        cmd_op = v.op; cmd_arg = v.arg;
        cfg_rsp_en = v.rsp; cfg_crc_chk = v.chk; cfg_rsp_long = v.lng;
        cfg_dummy = v.dmy; cfg_busy_wait = v.bsy;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: accepted start wipes prior status
        check(!sts_done && !sts_err && !sts_timeout && !rsp_full && busy, "R10",
              "status after start", {sts_done, sts_err, sts_timeout, rsp_full, busy}, 64'h1);
    endtask

    task automatic grab_frame(input vec_t v, input bit glitch);
        logic [47:0] exp_f, got;
        int gap;
        bit oe_ok;
        exp_f = {2'b01, v.op, v.arg, ref_crc({2'b01, v.op, v.arg}), 1'b1};
        gap = 1;
        while (!cmd_oe && gap < 200) begin
            @(negedge clk);
            gap++;
        end
        check(gap == (v.dmy ? 1 + DM : 1), "R2", "cycles to first frame bit",
              gap, v.dmy ? 1 + DM : 1);
        got = '0;
        oe_ok = 1'b1;
        for (int i = 0; i < 48; i++) begin
            got = {got[46:0], cmd_out};
            oe_ok &= cmd_oe;
            if (glitch && i == 10) begin start = 1'b1; cmd_op = ~v.op; end
            if (glitch && i == 11) begin start = 1'b0; cmd_op = v.op; end
            if (i < 47) @(negedge clk);
        end
        check(got == exp_f && oe_ok, glitch ? "R10" : "R1", "command frame", got, exp_f);
        @(negedge clk);
        check(!cmd_oe && cmd_out, "R1", "line released after frame", {cmd_oe, cmd_out}, 2'b01);
    endtask

    task automatic run(input vec_t v, input bit glitch);
        logic [135:0] rb;
        logic [143:0] pad;
        logic [31:0]  parg;
        int len, nf;
        bit exp_err;
        launch(v);
        grab_frame(v, glitch);
        rb = '0;
        len = v.lng ? 136 : 48;
        if (v.rsp) begin
            if (v.lng) begin
                rb = {2'b00, 6'h3F, 32'hC0DE_0000 | 32'(v.op), ~v.arg,
                      v.arg ^ 32'h1357_9BDF, 31'h44D5_E6F7, 1'b1};
            end else begin
                parg = v.arg ^ 32'h5A5A_0F0F;
                rb[47:0] = {2'b00, v.op, parg,
                            ref_crc({2'b00, v.op, parg}) ^ {6'd0, v.bad}, 1'b1};
            end
            repeat (int'(v.dly)) @(negedge clk);
            for (int i = len - 1; i >= 0; i--) begin
                cmd_in = rb[i];
                @(negedge clk);
            end
            cmd_in = 1'b1;
            if (v.bsy) begin
                dat0_in = 1'b0;
                repeat (6) @(negedge clk);
                check(!sts_done && busy, "R9", "finish held while DAT0 low",
                      {sts_done, busy}, 2'b01);
                dat0_in = 1'b1;
            end
        end
        for (int k = 0; k < 10 && !sts_done; k++) @(negedge clk);
        exp_err = v.rsp && v.chk && !v.lng && v.bad;
        check(sts_done && !busy, v.rsp ? "R4" : "R3", "transaction finished",
              {sts_done, busy}, 2'b10);
        check({sts_err, sts_crc_err, sts_timeout} == {exp_err, exp_err, 1'b0},
              v.lng ? "R7" : "R6", "error bits", {sts_err, sts_crc_err, sts_timeout},
              {exp_err, exp_err, 1'b0});
        if (v.rsp) begin
            pad = v.lng ? {rb, 8'h00} : {rb[47:0], 96'h0};
            nf = v.lng ? 3 : 1;
            for (int f = 0; f < nf; f++) begin
                check(rsp_full && {rsp_word, rsp_half} == pad[143 - 48*f -: 48], "R8",
                      "reply window", {rsp_full, rsp_word, rsp_half},
                      {1'b1, pad[143 - 48*f -: 48]});
                rsp_pop = 1'b1;
                @(negedge clk);
                rsp_pop = 1'b0;
            end
            check(!rsp_full, "R8", "full drops after last window", rsp_full, 0);
            rsp_pop = 1'b1;
            @(negedge clk);
            rsp_pop = 1'b0;
            @(negedge clk);
            check(!rsp_full, "R8", "pop while empty ignored", rsp_full, 0);
        end else begin
            check(!rsp_full, "R3", "no window without reply", rsp_full, 0);
        end
    endtask

    task automatic run_timeout();
        vec_t v;
        int waited;
        v = '{6'd9, 32'h0000_0042, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0};
        launch(v);
        grab_frame(v, 1'b0);
        waited = 0;
        while (!sts_done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check(waited == TO, "R5", "cycles until timeout", waited, TO);
        check(sts_timeout && sts_err && !sts_crc_err && !rsp_full && !busy, "R5",
              "timeout status", {sts_timeout, sts_err, sts_crc_err, rsp_full, busy}, 5'b11000);
        for (int i = 0; i < 48; i++) begin
            cmd_in = (i == 0) ? 1'b0 : 1'b1;
            @(negedge clk);
        end
        cmd_in = 1'b1;
        check(!rsp_full && !busy && sts_timeout, "R5", "late reply ignored",
              {rsp_full, busy, sts_timeout}, 3'b001);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!cmd_oe && cmd_out && !busy && !rsp_full && !sts_done && !sts_err
              && !sts_timeout && !sts_crc_err, "R11", "state in reset",
              {cmd_oe, cmd_out, busy, rsp_full, sts_done, sts_err}, 6'b010000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_oe && cmd_out && !busy && !rsp_full && !sts_done, "R11",
              "state after reset", {cmd_oe, cmd_out, busy, rsp_full, sts_done}, 5'b01000);

        for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

        run(VECS[0], 1'b1);
        run_timeout();
        run(VECS[1], 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule